// File: doc/BRIEF.md
# Timer-Paced Bundled-Data Handshake Link

This block carries one single-rail data word at a time from a sending side to a receiving side. A single request/acknowledge wire pair covers the whole word. There is no shared notion of "the data is settled by the next clock period". Each side instead runs its own countdown timer. The sender places a word on the link and holds it there. It signals a request event only after its own delay count has run out, so that the request can never race the data it announces. The receiver captures the word when it sees that request event. It then waits out its own delay count, which stands for the time it needs to consume the word, before it returns an acknowledge event. The sender may place the next word on the link only after that acknowledge.

Both delays are cycle counts taken from configuration inputs. Each count is sampled at the moment its timer starts. The link runs in one of two signalling modes. In transition mode, every toggle of request or acknowledge counts as one event. In level mode, both wires rise for a transfer and then both return to zero before the next one. A sender-idle output tells the user when a new word may be offered. Offers made while a transfer is outstanding are ignored.

Top module: `bd_link`

## Requirements
- R1: While rstN is low, reqLine and ackLine are 0, srcIdle is 1, rcvValid is 0, and rcvData and linkData are 0. Level mode (cfgTwoPhase = 0) is the active mode after reset.
- R2: A clock edge that sees srcIdle = 1 and sendValid = 1 issues a word. At that edge linkData takes sendData, and srcIdle is 0 from then on. linkData keeps its value until the source is idle again. sendValid and sendData have no effect while srcIdle is 0.
- R3: cfgSrcDelay is sampled at the issue edge. With that value Ds, the request event appears exactly Ds+1 edges after the issue edge, so it is never at the issue edge itself. Ds = 0 gives one cycle.
- R4: The edge after a request event captures linkData into rcvData. rcvValid is 1 for exactly that one cycle, and there is exactly one capture per transfer.
- R5: cfgSnkDelay is sampled at the capture edge. With that value Dk, the acknowledge event appears exactly Dk+1 edges after the capture edge. Dk = 0 is allowed.
- R6: In transition mode (cfgTwoPhase = 1), a request event is a toggle of reqLine and an acknowledge event is a toggle of ackLine. srcIdle returns to 1 one edge after the acknowledge toggle, and the lines keep their levels.
- R7: In level mode, the request event is reqLine rising and the acknowledge event is ackLine rising. reqLine falls one edge after ackLine rises, ackLine falls one edge after reqLine falls, and srcIdle returns one edge after ackLine falls.
- R8: cfgTwoPhase is taken at an issue edge only if reqLine is 0 at that edge. Otherwise the mode of the previous transfer stays in force for this transfer. So a switch to level mode made while the lines rest high takes effect one transfer later.
- R9: The sequence of captured words is exactly the sequence of issued words, in order, with no word lost or repeated.
- R10: Whenever srcIdle is 1, reqLine equals ackLine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that paces both timers |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTwoPhase | input | 1 | 1 selects transition signalling, 0 selects level signalling |
| cfgSrcDelay | input | CW | Source delay count, sampled at issue |
| cfgSnkDelay | input | CW | Sink delay count, sampled at capture |
| sendValid | input | 1 | Offer of a new word |
| sendData | input | DW | Word offered |
| srcIdle | output | 1 | Source can accept an offer |
| linkData | output | DW | Bundled data wires of the link |
| reqLine | output | 1 | Request wire |
| ackLine | output | 1 | Acknowledge wire |
| rcvValid | output | 1 | One-cycle capture pulse |
| rcvData | output | DW | Capture register |

## Verification
The bench builds the link with DW = 16 and CW = 5. The 5-bit count width brings the full-scale delay of 31 on both timers within a short run, alongside zero delays on both sides. It also runs a phase in which both delay inputs change in every cycle, so that only the values present at each timer's start edge may count. Both signalling modes are covered, including a switch to level mode while the lines rest high, which exercises the deferred mode change. Words offered during busy periods are noise that must never reach the capture register.

// File: rtl/bd_link_pkg.sv
package bd_link_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE,
    SRC_WAIT,
    SRC_HOLD,
    SRC_RTZ
  } srcState_t;

  typedef enum logic [1:0] {
    SNK_IDLE,
    SNK_WAIT,
    SNK_RTZ
  } snkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;    // load link word, start source timer
    logic srcTick;  // count source timer down
    logic capture;  // load capture register, start sink timer
    logic snkTick;  // count sink timer down
  } dpStrobe_t;

endpackage

// File: rtl/bd_link_timer.sv
module bd_link_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          tick,
  input  logic [CW-1:0] loadVal,
  output logic          done
);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (load) begin
      count <= loadVal;
    end else if (tick && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign done = (count == '0);

endmodule

// File: rtl/bd_link_dp.sv
module bd_link_dp
  import bd_link_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [DW-1:0] sendData,
  input  logic [CW-1:0] cfgSrcDelay,
  input  logic [CW-1:0] cfgSnkDelay,
  output logic [DW-1:0] linkData,
  output logic [DW-1:0] rcvData,
  output logic          srcDone,
  output logic          snkDone
);

  localparam int NTIMERS = 2;

  logic [NTIMERS-1:0]         tLoad;
  logic [NTIMERS-1:0]         tTick;
  logic [NTIMERS-1:0][CW-1:0] tVal;
  logic [NTIMERS-1:0]         tDone;

  assign tLoad = {strobe.capture, strobe.issue};
  assign tTick = {strobe.snkTick, strobe.srcTick};
  assign tVal  = {cfgSnkDelay, cfgSrcDelay};

  // index 0 paces the source, index 1 paces the sink
  for (genvar gi = 0; gi < NTIMERS; gi++) begin : gTimer
    bd_link_timer #(.CW(CW)) timerInst (
      .clk    (clk),
      .rstN   (rstN),
      .load   (tLoad[gi]),
      .tick   (tTick[gi]),
      .loadVal(tVal[gi]),
      .done   (tDone[gi])
    );
  end

  assign srcDone = tDone[0];
  assign snkDone = tDone[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkData <= '0;
      rcvData  <= '0;
    end else begin
      if (strobe.issue)   linkData <= sendData;
      if (strobe.capture) rcvData  <= linkData;
    end
  end

endmodule

// File: rtl/bd_link_ctrl.sv
module bd_link_ctrl
  import bd_link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sendValid,
  input  logic      cfgTwoPhase,
  input  logic      srcDone,
  input  logic      snkDone,
  output dpStrobe_t strobe,
  output logic      reqLine,
  output logic      ackLine,
  output logic      srcIdle,
  output logic      rcvValid
);

  srcState_t srcState;
  snkState_t snkState;
  logic      twoPhase;

  always_comb begin
    strobe.issue   = (srcState == SRC_IDLE) && sendValid;
    strobe.srcTick = (srcState == SRC_WAIT) && !srcDone;
    strobe.capture = (snkState == SNK_IDLE) && (reqLine != ackLine);
    strobe.snkTick = (snkState == SNK_WAIT) && !snkDone;
  end

  assign srcIdle = (srcState == SRC_IDLE);

  // source side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcState <= SRC_IDLE;
      reqLine  <= 1'b0;
      twoPhase <= 1'b0;
    end else begin
      unique case (srcState)
        SRC_IDLE: begin
          if (sendValid) begin
            if (!reqLine) twoPhase <= cfgTwoPhase;
            srcState <= SRC_WAIT;
          end
        end
        SRC_WAIT: begin
          if (srcDone) begin
            reqLine  <= twoPhase ? ~reqLine : 1'b1;
            srcState <= SRC_HOLD;
          end
        end
        SRC_HOLD: begin
          if (ackLine == reqLine) begin
            if (twoPhase) begin
              srcState <= SRC_IDLE;
            end else begin
              reqLine  <= 1'b0;
              srcState <= SRC_RTZ;
            end
          end
        end
        SRC_RTZ: begin
          if (!ackLine) srcState <= SRC_IDLE;
        end
        default: srcState <= SRC_IDLE;
      endcase
    end
  end

  // sink side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snkState <= SNK_IDLE;
      ackLine  <= 1'b0;
      rcvValid <= 1'b0;
    end else begin
      rcvValid <= 1'b0;
      unique case (snkState)
        SNK_IDLE: begin
          if (reqLine != ackLine) begin
            rcvValid <= 1'b1;
            snkState <= SNK_WAIT;
          end
        end
        SNK_WAIT: begin
          if (snkDone) begin
            ackLine  <= twoPhase ? ~ackLine : 1'b1;
            snkState <= twoPhase ? SNK_IDLE : SNK_RTZ;
          end
        end
        SNK_RTZ: begin
          if (!reqLine) begin
            ackLine  <= 1'b0;
            snkState <= SNK_IDLE;
          end
        end
        default: snkState <= SNK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bd_link.sv
module bd_link
  import bd_link_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgTwoPhase,
  input  logic [CW-1:0] cfgSrcDelay,
  input  logic [CW-1:0] cfgSnkDelay,
  input  logic          sendValid,
  input  logic [DW-1:0] sendData,
  output logic          srcIdle,
  output logic [DW-1:0] linkData,
  output logic          reqLine,
  output logic          ackLine,
  output logic          rcvValid,
  output logic [DW-1:0] rcvData
);

  dpStrobe_t strobe;
  logic      srcDone;
  logic      snkDone;

  bd_link_ctrl ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .sendValid  (sendValid),
    .cfgTwoPhase(cfgTwoPhase),
    .srcDone    (srcDone),
    .snkDone    (snkDone),
    .strobe     (strobe),
    .reqLine    (reqLine),
    .ackLine    (ackLine),
    .srcIdle    (srcIdle),
    .rcvValid   (rcvValid)
  );

  bd_link_dp #(.DW(DW), .CW(CW)) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sendData   (sendData),
    .cfgSrcDelay(cfgSrcDelay),
    .cfgSnkDelay(cfgSnkDelay),
    .linkData   (linkData),
    .rcvData    (rcvData),
    .srcDone    (srcDone),
    .snkDone    (snkDone)
  );

endmodule

// File: rtl/bd_link_chk.sv
module bd_link_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          srcIdle,
  input logic          reqLine,
  input logic          ackLine,
  input logic          rcvValid,
  input logic [DW-1:0] linkData
);

  // R2
  link_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcIdle && !$past(srcIdle)) |-> $stable(linkData));

  // R3
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srcIdle) |-> $stable(reqLine));

  // R4
  capture_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcvValid |-> $past(reqLine != ackLine));

  // R4
  capture_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcvValid |=> !rcvValid);

  // R5
  ack_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    rcvValid |-> $stable(ackLine));

  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcIdle |-> (reqLine == ackLine));

endmodule

bind bd_link bd_link_chk #(.DW(DW)) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .srcIdle (srcIdle),
  .reqLine (reqLine),
  .ackLine (ackLine),
  .rcvValid(rcvValid),
  .linkData(linkData)
);

// File: tb/bd_link_test.sv
module bd_link_test;

  localparam int DW = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgTwoPhase = 1'b0;
  logic [CW-1:0] cfgSrcDelay = '0;
  logic [CW-1:0] cfgSnkDelay = '0;
  logic          sendValid = 1'b0;
  logic [DW-1:0] sendData = '0;
  logic          srcIdle;
  logic [DW-1:0] linkData;
  logic          reqLine;
  logic          ackLine;
  logic          rcvValid;
  logic [DW-1:0] rcvData;

  bd_link #(.DW(DW), .CW(CW)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .cfgTwoPhase(cfgTwoPhase),
    .cfgSrcDelay(cfgSrcDelay),
    .cfgSnkDelay(cfgSnkDelay),
    .sendValid  (sendValid),
    .sendData   (sendData),
    .srcIdle    (srcIdle),
    .linkData   (linkData),
    .reqLine    (reqLine),
    .ackLine    (ackLine),
    .rcvValid   (rcvValid),
    .rcvData    (rcvData)
  );

  always #5 clk = ~clk;

  int nCmp = 0;
  int nBad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // behavioural reference: timeline of one transfer relative to its issue edge
  bit            mBusy, mReq, mAck, mValid, mTwo;
  int            mT, mDs, mDk;
  logic [DW-1:0] mLink, mData;
  logic [DW-1:0] q[$];
  int            nIssued, nCaught;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mReq = 0; mAck = 0; mValid = 0; mTwo = 0;
      mT = 0; mDs = 0; mDk = 0; mLink = '0; mData = '0;
      q.delete(); nIssued = 0; nCaught = 0;
    end else begin
      mValid = 0;
      if (!mBusy) begin
        if (sendValid) begin
          mBusy = 1; mT = 0; mDs = int'(cfgSrcDelay);
          if (!mReq) mTwo = cfgTwoPhase;
          mLink = sendData;
          q.push_back(sendData);
          nIssued++;
        end
      end else begin
        mT++;
        if (mT == mDs + 1) mReq = mTwo ? !mReq : 1'b1;
        if (mT == mDs + 2) begin
          mValid = 1; mDk = int'(cfgSnkDelay);
          mData = q.pop_front();
          nCaught++;
        end
        if (mT == mDs + mDk + 3) mAck = mTwo ? !mAck : 1'b1;
        if (mTwo) begin
          if (mT == mDs + mDk + 4) mBusy = 0;
        end else begin
          if (mT == mDs + mDk + 4) mReq = 0;
          if (mT == mDs + mDk + 5) mAck = 0;
          if (mT == mDs + mDk + 6) mBusy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      if (!rstN) begin
        chk("R1 reqLine", reqLine, 0);
        chk("R1 ackLine", ackLine, 0);
        chk("R1 srcIdle", srcIdle, 1);
        chk("R1 rcvValid", rcvValid, 0);
        chk("R1 rcvData", rcvData, 0);
        chk("R1 linkData", linkData, 0);
      end else begin
        chk("R3 R6 R7 reqLine", reqLine, mReq);
        chk("R5 R6 R7 ackLine", ackLine, mAck);
        chk("R2 R6 R7 srcIdle", srcIdle, !mBusy);
        chk("R2 linkData", linkData, mLink);
        chk("R4 rcvValid", rcvValid, mValid);
        chk("R4 R9 rcvData", rcvData, mData);
        chk("R10 idle lines", (srcIdle && reqLine != ackLine), 0);
      end
    end
    if (cycles > 60000) begin
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  logic [DW-1:0] seed = 16'hACE1;

  task automatic runPhase(input bit two, input int ds, input int dk,
                          input int n, input int gap, input bit vary);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfgTwoPhase = two;
      cfgSrcDelay = CW'(vary ? ds + (i % 5) : ds);
      cfgSnkDelay = CW'(vary ? dk + ((i * 3) % 7) : dk);
      sendValid   = (gap == 0) || (i % gap == 0);
      seed        = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
      sendData    = seed;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    sendValid = 0;
    while (!srcIdle) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // level mode, zero delays, back-to-back offers (R7, R3, R5)
    runPhase(0, 0, 0, 80, 0, 0);
    runPhase(0, 3, 7, 120, 0, 0);
    drain();
    // transition mode, zero and mixed delays (R6)
    runPhase(1, 0, 0, 80, 0, 0);
    runPhase(1, 5, 2, 150, 3, 0);
    drain();
    if (!reqLine) begin
      runPhase(1, 1, 1, 1, 0, 0);
      drain();
    end
    // R8: lines rest high, level mode requested, transition kept once
    chk("R8 lines high before switch", reqLine, 1);
    @(negedge clk);
    cfgTwoPhase = 0; cfgSrcDelay = 2; cfgSnkDelay = 1; sendValid = 1; sendData = 16'h5A5A;
    @(negedge clk);
    sendValid = 0;
    while (reqLine) @(negedge clk);
    chk("R8 deferred switch toggles req low", reqLine, 0);
    drain();
    runPhase(0, 2, 2, 60, 0, 0);
    drain();
    // full-scale counts and delays changing every cycle (R3, R5)
    runPhase(0, 31, 31, 300, 0, 0);
    runPhase(1, 31, 31, 300, 0, 0);
    runPhase(1, 0, 0, 200, 2, 1);
    runPhase(0, 20, 9, 300, 0, 1);
    drain();
    repeat (3) @(negedge clk);
    chk("R9 captured count equals issued", nCaught, nIssued);
    chk("R9 nothing left in flight", q.size(), 0);
    chk("R9 transfers happened", nIssued > 40, 1);
    done = 1;
    report();
  end

endmodule